// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits between a host write port and the internal machinery of a NOR-style flash array. The host issues single-cycle write strobes, each with an address and a data word. The block compares them against a fixed unlock protocol. Every command starts with two unlock writes. After that, a third write either selects a mode directly or leads into a longer sequence. A program takes four writes in total and an erase takes six.

When a sequence completes, the block emits a one-cycle start pulse for the chosen operation, with the target address and data held alongside it. It also keeps the mode state for manufacturer/device identification reads and for query reads. It answers those reads from a read-address input. While the array reports that an internal operation is running, every write is dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no start pulse is high, neither read mode flag is set, and `rdData` is zero at every read address.
- R2: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h, then any address/data produce `progStart` for exactly one cycle. The pulse rises in the cycle after the fourth write is sampled, and `opAddr`/`opData` equal that fourth write.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h produce `chipStart` with `opAddr` zero.
- R4: The same five-write prefix followed by any address with data 30h produces `sectStart`. `opAddr` equals that address with bits 10..0 cleared.
- R5: The same five-write prefix followed by any address with data 50h produces `blkStart`. `opAddr` equals that address with bits 14..0 cleared.
- R6: Command cycles compare only address bits 14..0 and data bits 7..0. Other address and data bits have no effect on decoding.
- R7: A third write of 5555h/90h sets `idMode`. In that mode, a read address with bits 19..1 zero returns 00BFh when bit 0 is 0 and 2782h when bit 0 is 1. Any other read address returns zero.
- R8: A third write of 5555h/98h sets `cfiMode`. In that mode, read addresses 10h, 11h and 12h return 0051h, 0052h and 0059h. Entering either mode clears the other.
- R9: Two ways lead back to normal read mode, clearing both flags: the three-write sequence ending in 5555h/F0h, or a single write with low data byte F0h to any address when no sequence is in progress.
- R10: A write that does not match the expected cycle of a sequence in progress abandons the sequence. Later writes must begin again from the first unlock write.
- R11: While `busy` is high, every write is ignored. This includes exit writes, so neither the mode flags nor the sequence position change and no start pulse is produced.
- R12: At most one start pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle host write strobe |
| wrAddr | input | 20 | Host write address |
| wrData | input | 16 | Host write data |
| busy | input | 1 | Internal program/erase in progress |
| rdAddr | input | 20 | Read address for identification/query data |
| progStart | output | 1 | Word program start pulse |
| chipStart | output | 1 | Whole-array erase start pulse |
| sectStart | output | 1 | Sector erase start pulse |
| blkStart | output | 1 | Block erase start pulse |
| opAddr | output | 20 | Target address of the last started operation |
| opData | output | 16 | Program data of the last started operation |
| idMode | output | 1 | Identification read mode active |
| cfiMode | output | 1 | Query read mode active |
| rdData | output | 16 | Identification/query read data |

## Verification
The hardest state to reach from the ports is a write that arrives while `busy` is high in the middle of a mode or sequence. The bench first enters identification mode and then raises `busy` while an exit is written. It also plays a complete program sequence under `busy`. In both cases it then confirms that the flag survives and no pulse appears, and that a clean sequence still works once `busy` drops. Abort handling is reached by corrupting the second unlock cycle and then sending the rest of a valid program sequence, which must start nothing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PROG,
    OP_CHIP,
    OP_SECT,
    OP_BLK
  } opKind_e;

  // strobes from the sequence control to the datapath
  typedef struct packed {
    opKind_e kind;
    logic    setId;
    logic    setCfi;
    logic    clrMode;
  } ctlStb_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CMD_ABITS = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrStb,
  input  logic                 busy,
  input  logic [CMD_ABITS-1:0] cmdAddr,
  input  logic [7:0]           cmdByte,
  output ctlStb_t              stb
);

  localparam logic [CMD_ABITS-1:0] KEY_ADDR_A = CMD_ABITS'('h5555);
  localparam logic [CMD_ABITS-1:0] KEY_ADDR_B = CMD_ABITS'('h2AAA);

  logic [2:0] step, nextStep;
  logic       eraseSeq, nextErase;
  logic       accept, atA, atB;

  assign accept = wrStb && !busy;
  assign atA    = (cmdAddr == KEY_ADDR_A);
  assign atB    = (cmdAddr == KEY_ADDR_B);

  always_comb begin
    nextStep    = step;
    nextErase   = eraseSeq;
    stb.kind    = OP_NONE;
    stb.setId   = 1'b0;
    stb.setCfi  = 1'b0;
    stb.clrMode = 1'b0;
    if (accept) begin
      case (step)
        3'd0: begin
          if (cmdByte == 8'hF0) stb.clrMode = 1'b1;
          else if (atA && cmdByte == 8'hAA) nextStep = 3'd1;
        end
        3'd1: nextStep = (atB && cmdByte == 8'h55) ? 3'd2 : 3'd0;
        3'd2: begin
          nextStep  = 3'd0;
          nextErase = 1'b0;
          if (atA) begin
            case (cmdByte)
              8'hA0: nextStep = 3'd3;
              8'h80: begin nextStep = 3'd3; nextErase = 1'b1; end
              8'h90: stb.setId   = 1'b1;
              8'h98: stb.setCfi  = 1'b1;
              8'hF0: stb.clrMode = 1'b1;
              default: nextStep = 3'd0;
            endcase
          end
        end
        3'd3: begin
          if (!eraseSeq) begin
            stb.kind = OP_PROG;
            nextStep = 3'd0;
          end else begin
            nextStep = (atA && cmdByte == 8'hAA) ? 3'd4 : 3'd0;
          end
        end
        3'd4: nextStep = (atB && cmdByte == 8'h55) ? 3'd5 : 3'd0;
        3'd5: begin
          nextStep = 3'd0;
          if (atA && cmdByte == 8'h10) stb.kind = OP_CHIP;
          else if (cmdByte == 8'h30)   stb.kind = OP_SECT;
          else if (cmdByte == 8'h50)   stb.kind = OP_BLK;
        end
        default: nextStep = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= 3'd0;
      eraseSeq <= 1'b0;
    end else begin
      step     <= nextStep;
      eraseSeq <= nextErase;
    end
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W   = 20,
  parameter int                DATA_W   = 16,
  parameter int                SECT_LSB = 11,
  parameter int                BLK_LSB  = 15,
  parameter logic [DATA_W-1:0] ID_MFR   = DATA_W'('h00BF),
  parameter logic [DATA_W-1:0] ID_DEV   = DATA_W'('h2782)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStb_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              progStart,
  output logic              chipStart,
  output logic              sectStart,
  output logic              blkStart,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              idMode,
  output logic              cfiMode,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      progStart <= 1'b0;
      chipStart <= 1'b0;
      sectStart <= 1'b0;
      blkStart  <= 1'b0;
      opAddr    <= '0;
      opData    <= '0;
      idMode    <= 1'b0;
      cfiMode   <= 1'b0;
    end else begin
      progStart <= (stb.kind == OP_PROG);
      chipStart <= (stb.kind == OP_CHIP);
      sectStart <= (stb.kind == OP_SECT);
      blkStart  <= (stb.kind == OP_BLK);
      if (stb.kind != OP_NONE) begin
        opData <= (stb.kind == OP_PROG) ? wrData : '0;
        case (stb.kind)
          OP_PROG: opAddr <= wrAddr;
          OP_SECT: opAddr <= wrAddr & SECT_MASK;
          OP_BLK:  opAddr <= wrAddr & BLK_MASK;
          default: opAddr <= '0;
        endcase
      end
      if (stb.clrMode) begin
        idMode  <= 1'b0;
        cfiMode <= 1'b0;
      end else if (stb.setId) begin
        idMode  <= 1'b1;
        cfiMode <= 1'b0;
      end else if (stb.setCfi) begin
        idMode  <= 1'b0;
        cfiMode <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (idMode && rdAddr[ADDR_W-1:1] == '0) begin
      rdData = rdAddr[0] ? ID_DEV : ID_MFR;
    end else if (cfiMode) begin
      if (rdAddr == ADDR_W'('h10))      rdData = DATA_W'('h0051);
      else if (rdAddr == ADDR_W'('h11)) rdData = DATA_W'('h0052);
      else if (rdAddr == ADDR_W'('h12)) rdData = DATA_W'('h0059);
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int CMD_ABITS = 15,
  parameter int SECT_LSB  = 11,
  parameter int BLK_LSB   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              progStart,
  output logic              chipStart,
  output logic              sectStart,
  output logic              blkStart,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              idMode,
  output logic              cfiMode,
  output logic [DATA_W-1:0] rdData
);

  ctlStb_t stb;

  flash_cmd_ctrl #(.CMD_ABITS(CMD_ABITS)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrStb   (wrStb),
    .busy    (busy),
    .cmdAddr (wrAddr[CMD_ABITS-1:0]),
    .cmdByte (wrData[7:0]),
    .stb     (stb)
  );

  flash_cmd_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SECT_LSB (SECT_LSB),
    .BLK_LSB  (BLK_LSB)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .progStart (progStart),
    .chipStart (chipStart),
    .sectStart (sectStart),
    .blkStart  (blkStart),
    .opAddr    (opAddr),
    .opData    (opData),
    .idMode    (idMode),
    .cfiMode   (cfiMode),
    .rdData    (rdData)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W   = 20,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wrStb,
  input logic              progStart,
  input logic              chipStart,
  input logic              sectStart,
  input logic              blkStart,
  input logic [ADDR_W-1:0] opAddr,
  input logic              idMode,
  input logic              cfiMode
);

  // R12
  single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({progStart, chipStart, sectStart, blkStart}));

  // R12
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    progStart |=> !progStart);

  // R11
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(progStart || chipStart || sectStart || blkStart));

  // R11
  busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(idMode) && $stable(cfiMode)));

  // R8
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idMode && cfiMode));

  // R7
  id_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idMode) |-> $past(wrStb));

  // R4
  sect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sectStart |-> (opAddr[SECT_LSB-1:0] == '0));

  // R5
  blk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blkStart |-> (opAddr[BLK_LSB-1:0] == '0));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .SECT_LSB (SECT_LSB),
  .BLK_LSB  (BLK_LSB)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .wrStb     (wrStb),
  .progStart (progStart),
  .chipStart (chipStart),
  .sectStart (sectStart),
  .blkStart  (blkStart),
  .opAddr    (opAddr),
  .idMode    (idMode),
  .cfiMode   (cfiMode)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrStb = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        busy = 1'b0;
  logic [19:0] rdAddr = '0;
  logic        progStart, chipStart, sectStart, blkStart;
  logic [19:0] opAddr;
  logic [15:0] opData;
  logic        idMode, cfiMode;
  logic [15:0] rdData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .rdAddr(rdAddr), .progStart(progStart), .chipStart(chipStart),
    .sectStart(sectStart), .blkStart(blkStart), .opAddr(opAddr), .opData(opData),
    .idMode(idMode), .cfiMode(cfiMode), .rdData(rdData)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one host write; returns at the negedge where its result is visible
  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic rd(input string req, input logic [19:0] a, input logic [15:0] exp);
    rdAddr = a;
    #1;
    chk(req, {16'h0, rdData}, {16'h0, exp});
  endtask

  function automatic logic [3:0] pulses();
    return {progStart, chipStart, sectStart, blkStart};
  endfunction

  task automatic unlock();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic erasePrefix();
    unlock();
    wr(20'h05555, 16'h0080);
    unlock();
  endtask

  task automatic t_reset();
    chk("R1 pulses", {28'h0, pulses()}, 32'h0);
    chk("R1 idMode", {31'h0, idMode}, 32'h0);
    chk("R1 cfiMode", {31'h0, cfiMode}, 32'h0);
    rd("R1 rdData", 20'h00001, 16'h0000);
  endtask

  task automatic t_program();
    unlock();
    wr(20'h05555, 16'h00A0);
    chk("R2 no early pulse", {28'h0, pulses()}, 32'h0);
    wr(20'h12345, 16'hBEEF);
    chk("R2 progStart", {28'h0, pulses()}, 32'h8);
    chk("R2 opAddr", {12'h0, opAddr}, 32'h12345);
    chk("R2 opData", {16'h0, opData}, 32'hBEEF);
    @(negedge clk);
    chk("R12 one cycle", {28'h0, pulses()}, 32'h0);
  endtask

  task automatic t_chip();
    erasePrefix();
    wr(20'h05555, 16'h0010);
    chk("R3 chipStart", {28'h0, pulses()}, 32'h4);
    chk("R3 opAddr", {12'h0, opAddr}, 32'h0);
    @(negedge clk);
    chk("R12 chip one cycle", {28'h0, pulses()}, 32'h0);
  endtask

  task automatic t_sector();
    erasePrefix();
    wr(20'hABCDE, 16'h0030);
    chk("R4 sectStart", {28'h0, pulses()}, 32'h2);
    chk("R4 opAddr", {12'h0, opAddr}, 32'hAB800);
  endtask

  task automatic t_block();
    erasePrefix();
    wr(20'hABCDE, 16'h0050);
    chk("R5 blkStart", {28'h0, pulses()}, 32'h1);
    chk("R5 opAddr", {12'h0, opAddr}, 32'hA8000);
  endtask

  task automatic t_upperIgnored();
    wr(20'hF5555, 16'h12AA);
    wr(20'h3AAAA, 16'hFF55);
    wr(20'h0D555, 16'h77A0);
    wr(20'h00042, 16'h1234);
    chk("R6 progStart", {28'h0, pulses()}, 32'h8);
    chk("R6 opData", {16'h0, opData}, 32'h1234);
  endtask

  task automatic t_idMode();
    unlock();
    wr(20'h05555, 16'h0090);
    chk("R7 idMode", {31'h0, idMode}, 32'h1);
    rd("R7 mfr", 20'h00000, 16'h00BF);
    rd("R7 dev", 20'h00001, 16'h2782);
    rd("R7 other", 20'h00002, 16'h0000);
    wr(20'h00000, 16'h00F0);
    chk("R9 single exit", {31'h0, idMode}, 32'h0);
  endtask

  task automatic t_cfiMode();
    unlock();
    wr(20'h05555, 16'h0090);
    unlock();
    wr(20'h05555, 16'h0098);
    chk("R8 cfiMode", {31'h0, cfiMode}, 32'h1);
    chk("R8 id cleared", {31'h0, idMode}, 32'h0);
    rd("R8 Q", 20'h00010, 16'h0051);
    rd("R8 R", 20'h00011, 16'h0052);
    rd("R8 Y", 20'h00012, 16'h0059);
    unlock();
    wr(20'h05555, 16'h00F0);
    chk("R9 seq exit", {31'h0, cfiMode}, 32'h0);
    rd("R9 read zero", 20'h00010, 16'h0000);
  endtask

  task automatic t_abort();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0054);
    wr(20'h05555, 16'h00A0);
    wr(20'h00100, 16'h5A5A);
    chk("R10 no start", {28'h0, pulses()}, 32'h0);
    erasePrefix();
    wr(20'h05555, 16'h0011);
    chk("R10 bad erase", {28'h0, pulses()}, 32'h0);
  endtask

  task automatic t_busy();
    unlock();
    wr(20'h05555, 16'h0090);
    busy = 1'b1;
    wr(20'h00000, 16'h00F0);
    chk("R11 exit ignored", {31'h0, idMode}, 32'h1);
    unlock();
    wr(20'h05555, 16'h00A0);
    wr(20'h00200, 16'h1111);
    chk("R11 no start", {28'h0, pulses()}, 32'h0);
    busy = 1'b0;
    wr(20'h00000, 16'h00F0);
    chk("R11 exit after busy", {31'h0, idMode}, 32'h0);
    unlock();
    wr(20'h05555, 16'h00A0);
    wr(20'h00300, 16'h2222);
    chk("R11 program after busy", {28'h0, pulses()}, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_chip();
    t_sector();
    t_block();
    t_upperIgnored();
    t_idMode();
    t_cfiMode();
    t_abort();
    t_busy();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule